// File: doc/BRIEF.md
# External Bus Idle Gap Inserter

This block sits between two consecutive external bus accesses. It decides how many idle clock cycles must pass before the next access may start. When an access ends, the block looks at four independent idle requirements and takes the largest of them as the length of the gap.

- **Programmed gap.** This comes from a 3-bit setting that the access pattern selects. A DMA access uses its own dedicated setting. Any other access uses one of several per-space settings.
- **Memory-timing gap.** This is either the longest of three 2-bit timing fields, or a single wait-mask cycle.
- **Sequential chain.** This is the sum of three raw delays that happen one after the other.
- **Type-switch penalty.** This applies only when the previous and next accesses target different memory types.

The block loads the largest value into a down-counter and holds off the next access until the counter has drained.

The next access is a valid/ready stream on the request side. The requester raises `req_valid_i` and the block answers with `req_ready_o`. A transfer happens in a cycle where both are high, and `grant_o` pulses in that cycle. Back-pressure works as follows:
- `req_ready_o` stays low while any idle cycle is still owed.
- A request seen while ready is low is remembered internally, even if the requester drops `req_valid_i`.
- The remembered request is granted exactly once, in the first cycle that ready is high.
- Register fields and access descriptors are plain levels. They are sampled in the cycle where the `acc_done_i` strobe is high.

Top module: `idle_gap_inserter`

## Requirements
- R1: A 3-bit gap code 0..7 means 0, 1, 2, 4, 6, 8, 10 and 12 idle cycles respectively.
- R2: The programmed gap is selected by the first matching rule below:
  - When `dma_i`=1, it uses `dma_code_i`.
  - Otherwise, when the next access writes, it uses `ww_code_i`.
  - Otherwise, when the previous access wrote, it uses `rw_same_code_i` if `same_space_i`=1 and `rw_diff_code_i` if not.
  - Otherwise, it uses `rr_same_code_i` if `same_space_i`=1 and `rr_diff_code_i` if not.
- R3: When `tm_sel_i`=1, the memory-timing gap is the largest of (field+1) over the three 2-bit fields of `tm_fields_i`. Those fields are bits [1:0] precharge, [3:2] write recovery and [5:4] row cycle. When `tm_sel_i`=0, the gap is 1 cycle if `wmask_i`=1 and 0 if not.
- R4: The chain gap is the sum of the three 2-bit raw delays in `chain_i`. Those are bits [1:0] read transfer, [3:2] internal bus idle and [5:4] write wait.
- R5: The type-switch gap is the R1 value of `type_code_i` when `type_chg_i`=1. It is 0 (no effect) when `type_chg_i`=0.
- R6: After an `acc_done_i` cycle with a largest gap N>0, `idle_o` is high for exactly the next N cycles. `req_ready_o` is low during those cycles and returns high in the following cycle.
- R7: When the largest gap is 0, `req_ready_o` is high in the same cycle as `acc_done_i`.
- R8: A request seen while `req_ready_o` is low is held. `grant_o` pulses once, in the first ready cycle, even if `req_valid_i` was dropped.
- R9: When `acc_done_i` arrives while idle, the counter continues with the larger of its decremented remaining count and the new gap.
- R10: After reset, `idle_o`=0, `req_ready_o`=1 and `grant_o`=0 while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_done_i | input | 1 | Access-finished strobe; fields are sampled in this cycle |
| dma_i | input | 1 | Access is a DMA transfer |
| prev_wr_i | input | 1 | Previous access was a write |
| next_wr_i | input | 1 | Next access is a write |
| same_space_i | input | 1 | Next access targets the same space as the previous one |
| dma_code_i | input | 3 | DMA gap code |
| ww_code_i | input | 3 | Write-next gap code |
| rw_diff_code_i | input | 3 | Read-after-write gap code, different space |
| rw_same_code_i | input | 3 | Read-after-write gap code, same space |
| rr_diff_code_i | input | 3 | Read-after-read gap code, different space |
| rr_same_code_i | input | 3 | Read-after-read gap code, same space |
| tm_sel_i | input | 1 | 1: use timing fields, 0: use wait mask |
| tm_fields_i | input | 6 | Three 2-bit memory timing fields |
| wmask_i | input | 1 | Wait-mask enable (one idle cycle) |
| chain_i | input | 6 | Three 2-bit sequential raw delays |
| type_chg_i | input | 1 | Previous and next memory types differ |
| type_code_i | input | 3 | Type-switch gap code |
| req_valid_i | input | 1 | Next access request |
| req_ready_o | output | 1 | Next access may start |
| idle_o | output | 1 | Idle cycles are being inserted |
| grant_o | output | 1 | Next access granted this cycle |

## Verification
The gap computation is tried with patterns in which each source in turn is the largest one. This shows that every source reaches the counter, and that the maximum is taken rather than a sum or a fixed priority. Each alternative pair is tried in both directions while a large value sits on the unused side:
- DMA setting against per-space setting;
- same space against different space;
- timing fields against wait mask;
- type change against no type change.

A wrong selector shows up as a wrong idle length. A pattern with every source at zero separates the same-cycle grant from a one-cycle-late grant. Directed sequences drop a request in the middle of an idle period, and restart the counter with a smaller and with a larger gap. These show that pending requests are kept and that the counter keeps the larger count.

// File: rtl/idle_ins_pkg.sv
package idle_ins_pkg;
  localparam int CODE_W  = 3;
  localparam int TF_W    = 2;
  localparam int CNT_W   = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int NSRC    = 4;

  typedef enum logic [1:0] {
    K_DMA = 2'd0,
    K_WW  = 2'd1,
    K_RW  = 2'd2,
    K_RR  = 2'd3
  } acc_kind_e;

  // gap code -> cycles: 0,1,2 then 2*(code-1)
  function automatic logic [CNT_W-1:0] code_cycles(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] wide;
    wide = CNT_W'(code);
    if (code < CODE_W'(3)) return wide;
    return (wide - CNT_W'(1)) << 1;
  endfunction
endpackage

// File: rtl/idle_prog_sel.sv
module idle_prog_sel
  import idle_ins_pkg::*;
(
  input  logic              dma_i,
  input  logic              prev_wr_i,
  input  logic              next_wr_i,
  input  logic              same_space_i,
  input  logic [CODE_W-1:0] dma_code_i,
  input  logic [CODE_W-1:0] ww_code_i,
  input  logic [CODE_W-1:0] rw_diff_code_i,
  input  logic [CODE_W-1:0] rw_same_code_i,
  input  logic [CODE_W-1:0] rr_diff_code_i,
  input  logic [CODE_W-1:0] rr_same_code_i,
  output logic [CNT_W-1:0]  cyc_o
);
  acc_kind_e         kind;
  logic [CODE_W-1:0] code;

  always_comb begin
    if (dma_i)          kind = K_DMA;
    else if (next_wr_i) kind = K_WW;
    else if (prev_wr_i) kind = K_RW;
    else                kind = K_RR;
  end

  always_comb begin
    case (kind)
      K_DMA: code = dma_code_i;
      K_WW:  code = ww_code_i;
      K_RW:  code = same_space_i ? rw_same_code_i : rw_diff_code_i;
      K_RR:  code = same_space_i ? rr_same_code_i : rr_diff_code_i;
      default: code = '0;
    endcase
  end

  assign cyc_o = code_cycles(code);
endmodule

// File: rtl/idle_timing_sel.sv
module idle_timing_sel
  import idle_ins_pkg::*;
#(
  parameter int TF_N = 3
) (
  input  logic                 tm_sel_i,
  input  logic [TF_N*TF_W-1:0] tm_fields_i,
  input  logic                 wmask_i,
  output logic [CNT_W-1:0]     cyc_o
);
  logic [CNT_W-1:0] fcyc [TF_N];
  logic [CNT_W-1:0] best;

  for (genvar g = 0; g < TF_N; g++) begin : g_field
    assign fcyc[g] = CNT_W'(tm_fields_i[g*TF_W +: TF_W]) + CNT_W'(1);
  end

  always_comb begin
    best = '0;
    for (int i = 0; i < TF_N; i++)
      if (fcyc[i] > best) best = fcyc[i];
  end

  assign cyc_o = tm_sel_i ? best : {{(CNT_W-1){1'b0}}, wmask_i};
endmodule

// File: rtl/idle_seq_sum.sv
module idle_seq_sum
  import idle_ins_pkg::*;
#(
  parameter int CHAIN_N = 3,
  parameter int CH_W    = 2
) (
  input  logic [CHAIN_N*CH_W-1:0] chain_i,
  output logic [CNT_W-1:0]        cyc_o
);
  localparam int SUM_W = CH_W + $clog2(CHAIN_N + 1);

  logic [SUM_W-1:0] part [CHAIN_N+1];

  assign part[0] = '0;
  for (genvar g = 0; g < CHAIN_N; g++) begin : g_stage
    assign part[g+1] = part[g] + SUM_W'(chain_i[g*CH_W +: CH_W]);
  end

  always_comb begin
    if (int'(part[CHAIN_N]) > CNT_MAX) cyc_o = CNT_W'(CNT_MAX);
    else                               cyc_o = CNT_W'(part[CHAIN_N]);
  end
endmodule

// File: rtl/idle_hold_ctr.sv
module idle_hold_ctr
  import idle_ins_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  output logic             idle_o,
  output logic             grant_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, dec, nxt;
  logic             pend_q;

  assign dec = (cnt_q != '0) ? cnt_q - CNT_W'(1) : '0;

  always_comb begin
    nxt = dec;
    if (load_i && (load_val_i > dec)) nxt = load_val_i;
  end

  assign req_ready_o = (cnt_q == '0) && !(load_i && (load_val_i != '0));
  assign grant_o     = req_ready_o && (req_valid_i || pend_q);
  assign idle_o      = (cnt_q != '0);
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= nxt;
      if (grant_o)                         pend_q <= 1'b0;
      else if (req_valid_i && !req_ready_o) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
  import idle_ins_pkg::*;
#(
  parameter int TF_N    = 3,
  parameter int CHAIN_N = 3,
  parameter int CH_W    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_done_i,
  input  logic                    dma_i,
  input  logic                    prev_wr_i,
  input  logic                    next_wr_i,
  input  logic                    same_space_i,
  input  logic [CODE_W-1:0]       dma_code_i,
  input  logic [CODE_W-1:0]       ww_code_i,
  input  logic [CODE_W-1:0]       rw_diff_code_i,
  input  logic [CODE_W-1:0]       rw_same_code_i,
  input  logic [CODE_W-1:0]       rr_diff_code_i,
  input  logic [CODE_W-1:0]       rr_same_code_i,
  input  logic                    tm_sel_i,
  input  logic [TF_N*TF_W-1:0]    tm_fields_i,
  input  logic                    wmask_i,
  input  logic [CHAIN_N*CH_W-1:0] chain_i,
  input  logic                    type_chg_i,
  input  logic [CODE_W-1:0]       type_code_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  output logic                    idle_o,
  output logic                    grant_o
);
  logic [CNT_W-1:0] src [NSRC];
  logic [CNT_W-1:0] gap_max;
  logic [CNT_W-1:0] idle_cnt;

  idle_prog_sel u_prog (
    .dma_i          (dma_i),
    .prev_wr_i      (prev_wr_i),
    .next_wr_i      (next_wr_i),
    .same_space_i   (same_space_i),
    .dma_code_i     (dma_code_i),
    .ww_code_i      (ww_code_i),
    .rw_diff_code_i (rw_diff_code_i),
    .rw_same_code_i (rw_same_code_i),
    .rr_diff_code_i (rr_diff_code_i),
    .rr_same_code_i (rr_same_code_i),
    .cyc_o          (src[0])
  );

  idle_timing_sel #(.TF_N(TF_N)) u_timing (
    .tm_sel_i    (tm_sel_i),
    .tm_fields_i (tm_fields_i),
    .wmask_i     (wmask_i),
    .cyc_o       (src[1])
  );

  idle_seq_sum #(.CHAIN_N(CHAIN_N), .CH_W(CH_W)) u_chain (
    .chain_i (chain_i),
    .cyc_o   (src[2])
  );

  assign src[3] = type_chg_i ? code_cycles(type_code_i) : '0;

  always_comb begin
    gap_max = '0;
    for (int i = 0; i < NSRC; i++)
      if (src[i] > gap_max) gap_max = src[i];
  end

  idle_hold_ctr u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (acc_done_i),
    .load_val_i  (gap_max),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .idle_o      (idle_o),
    .grant_o     (grant_o),
    .cnt_o       (idle_cnt)
  );
endmodule

// File: rtl/idle_gap_chk.sv
module idle_gap_chk
  import idle_ins_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             acc_done_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             idle_o,
  input logic             grant_o,
  input logic [CNT_W-1:0] idle_cnt
);
  // R6
  idle_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !req_ready_o);

  // R6
  countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && !acc_done_i) |=> (idle_cnt == $past(idle_cnt) - CNT_W'(1)));

  // R7
  free_bus_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && !acc_done_i) |-> req_ready_o);

  // R8
  grant_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> req_ready_o);

  // R8
  pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_ready_o) |=> (!req_ready_o || grant_o));

  // R9
  reload_keeps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done_i && (idle_cnt > CNT_W'(1))) |=> idle_o);
endmodule

bind idle_gap_inserter idle_gap_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_done_i  (acc_done_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .idle_o      (idle_o),
  .grant_o     (grant_o),
  .idle_cnt    (idle_cnt)
);

// File: tb/idle_gap_inserter_test.sv
`timescale 1ns/100ps
module idle_gap_inserter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_done_i = 0, dma_i = 0, prev_wr_i = 0, next_wr_i = 0, same_space_i = 0;
  logic [2:0] dma_code_i = 0, ww_code_i = 0, rw_diff_code_i = 0, rw_same_code_i = 0;
  logic [2:0] rr_diff_code_i = 0, rr_same_code_i = 0, type_code_i = 0;
  logic tm_sel_i = 0, wmask_i = 0, type_chg_i = 0, req_valid_i = 0;
  logic [5:0] tm_fields_i = 0, chain_i = 0;
  logic req_ready_o, idle_o, grant_o;

  always #2.5 clk = ~clk;

  idle_gap_inserter uut (.*);

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit sb_en = 0;
  string cur_req = "";

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int cyc3(input int c);
    case (c)
      0: return 0;  1: return 1;  2: return 2;  3: return 4;
      4: return 6;  5: return 8;  6: return 10; default: return 12;
    endcase
  endfunction

  function automatic int model_gap();
    int s1, s2, s3, s4, m;
    if (dma_i)          s1 = cyc3(dma_code_i);
    else if (next_wr_i) s1 = cyc3(ww_code_i);
    else if (prev_wr_i) s1 = same_space_i ? cyc3(rw_same_code_i) : cyc3(rw_diff_code_i);
    else                s1 = same_space_i ? cyc3(rr_same_code_i) : cyc3(rr_diff_code_i);
    if (tm_sel_i) begin
      s2 = 0;
      for (int i = 0; i < 3; i++)
        if (int'(tm_fields_i[2*i +: 2]) + 1 > s2) s2 = int'(tm_fields_i[2*i +: 2]) + 1;
    end else s2 = int'(wmask_i);
    s3 = int'(chain_i[1:0]) + int'(chain_i[3:2]) + int'(chain_i[5:4]);
    s4 = type_chg_i ? cyc3(type_code_i) : 0;
    m = s1;
    if (s2 > m) m = s2;
    if (s3 > m) m = s3;
    if (s4 > m) m = s4;
    return m;
  endfunction

  task automatic clear_fields();
    dma_i = 0; prev_wr_i = 0; next_wr_i = 0; same_space_i = 0;
    dma_code_i = 0; ww_code_i = 0; rw_diff_code_i = 0; rw_same_code_i = 0;
    rr_diff_code_i = 0; rr_same_code_i = 0; type_code_i = 0;
    tm_sel_i = 0; wmask_i = 0; type_chg_i = 0; tm_fields_i = 0; chain_i = 0;
  endtask

  // driver: push expected gap, pulse done, wait out the gap
  task automatic run_access(input string req);
    int e;
    e = model_gap();
    @(negedge clk);
    cur_req = req;
    exp_q.push_back(e);
    acc_done_i = 1;
    @(negedge clk);
    acc_done_i = 0;
    repeat (e + 2) @(negedge clk);
    clear_fields();
  endtask

  // monitor: pop expected gap on each done, measure idle run
  int  cur_exp = 0, obs = 0;
  bit  active = 0;
  always begin
    @(negedge clk);
    #1;
    if (sb_en) begin
      if (active) begin
        if (idle_o) obs++;
        else begin
          check(obs == cur_exp, {cur_req, " idle length"}, obs, cur_exp);
          check(req_ready_o == 1'b1, "R6 ready after gap", int'(req_ready_o), 1);
          active = 0;
        end
      end
      if (acc_done_i) begin
        cur_exp = exp_q.pop_front();
        if (cur_exp == 0)
          check(req_ready_o == 1'b1, {cur_req, " R7 same-cycle ready"}, int'(req_ready_o), 1);
        else begin
          check(req_ready_o == 1'b0, {cur_req, " R6 ready low at done"}, int'(req_ready_o), 0);
          active = 1;
          obs = 0;
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int first, grants, idles;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    check(idle_o == 1'b0, "R10 idle", int'(idle_o), 0);
    check(req_ready_o == 1'b1, "R10 ready", int'(req_ready_o), 1);
    check(grant_o == 1'b0, "R10 grant", int'(grant_o), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    check(req_ready_o == 1'b1 && idle_o == 1'b0, "R10 after release", int'(req_ready_o), 1);

    sb_en = 1;
    // R7 all sources zero
    run_access("R7");
    // R2 R1 DMA code wins: 12
    dma_i = 1; dma_code_i = 7; ww_code_i = 1; next_wr_i = 1;
    run_access("R2 R1 dma");
    // R2 write next, DMA code ignored: 8
    next_wr_i = 1; ww_code_i = 5; dma_code_i = 7;
    run_access("R2 ww");
    // R2 read after write, different space: 4
    prev_wr_i = 1; rw_diff_code_i = 3; rw_same_code_i = 6;
    run_access("R2 rw diff");
    // R2 read after write, same space: 10
    prev_wr_i = 1; same_space_i = 1; rw_diff_code_i = 3; rw_same_code_i = 6;
    run_access("R2 rw same");
    // R2 read after read, different space: 6
    rr_diff_code_i = 4; rr_same_code_i = 2;
    run_access("R2 rr diff");
    // R2 read after read, same space: 2
    same_space_i = 1; rr_diff_code_i = 4; rr_same_code_i = 2;
    run_access("R2 rr same");
    // R3 timing fields dominate: 4
    next_wr_i = 1; ww_code_i = 1; tm_sel_i = 1; tm_fields_i = 6'b00_01_11;
    run_access("R3 timing");
    // R3 wait mask path, fields ignored: 1
    tm_sel_i = 0; wmask_i = 1; tm_fields_i = 6'b11_11_11;
    run_access("R3 mask");
    // R4 chain sum dominates: 9
    next_wr_i = 1; ww_code_i = 5; chain_i = 6'b11_11_11;
    run_access("R4 chain");
    // R4 partial chain: 1+2+0 = 3
    chain_i = 6'b00_10_01;
    run_access("R4 chain partial");
    // R5 type change: 12
    next_wr_i = 1; ww_code_i = 1; type_chg_i = 1; type_code_i = 7;
    run_access("R5 type");
    // R5 no type change, code ignored: 2
    next_wr_i = 1; ww_code_i = 2; type_chg_i = 0; type_code_i = 7;
    run_access("R5 no type");
    repeat (3) @(negedge clk);
    sb_en = 0;

    // R8 request during idle is held: gap 6
    next_wr_i = 1; ww_code_i = 4;
    acc_done_i = 1;
    @(negedge clk);
    acc_done_i = 0; req_valid_i = 1;
    #1;
    check(grant_o == 1'b0 && req_ready_o == 1'b0, "R8 no grant while idle", int'(grant_o), 0);
    @(negedge clk);
    req_valid_i = 0;
    first = -1; grants = 0;
    for (int k = 2; k < 20; k++) begin
      #1;
      if (grant_o) begin grants++; if (first < 0) first = k; end
      @(negedge clk);
    end
    check(first == 7, "R8 grant cycle", first, 7);
    check(grants == 1, "R8 single grant", grants, 1);
    clear_fields();

    // R9 reload with smaller gap keeps remaining: total idle 8
    next_wr_i = 1; ww_code_i = 5;
    acc_done_i = 1;
    idles = 0;
    for (int k = 0; k < 25; k++) begin
      if (k == 1) acc_done_i = 0;
      if (k == 3) begin ww_code_i = 2; acc_done_i = 1; end
      if (k == 4) acc_done_i = 0;
      #1;
      if (idle_o) idles++;
      @(negedge clk);
    end
    check(idles == 8, "R9 smaller reload", idles, 8);

    // R9 reload with larger gap extends: 3 + 12 = 15
    ww_code_i = 5;
    acc_done_i = 1;
    idles = 0;
    for (int k = 0; k < 30; k++) begin
      if (k == 1) acc_done_i = 0;
      if (k == 3) begin ww_code_i = 7; acc_done_i = 1; end
      if (k == 4) acc_done_i = 0;
      #1;
      if (idle_o) idles++;
      @(negedge clk);
    end
    check(idles == 15, "R9 larger reload", idles, 15);
    #1;
    check(req_ready_o == 1'b1, "R6 ready at end", int'(req_ready_o), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule